// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block sits inside a memory controller and decides when a refresh command is owed to a multi-bank DRAM. A free-running interval timer counts controller clock cycles. Each time it expires, one refresh becomes owed. The timer's reload length is the programmed all-bank interval. It is halved while the device reports that it is running hot, and it is divided by the bank count when refreshes go to one bank at a time. Owed refreshes are offered to the command arbiter through a request/accept handshake. The arbiter may postpone them up to a fixed limit, after which the request is flagged as mandatory.

After each accepted refresh, the block holds the targeted bank busy for a programmed refresh cycle time. In all-bank mode it holds every bank busy. The arbiter uses the per-bank busy flags to keep reads and writes away from a bank that is being refreshed. In per-bank mode the other banks stay usable. Refresh commands carry no row address, because the device steps through its rows by itself. Per-bank commands name only a bank, and the block visits the banks in a fixed rotation.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ref_req` and `ref_urgent` are 0, `bank_busy` is all zeros and `ref_bank` is 0.
- R2: With `temp_hot`=0 and `pb_mode`=0, one refresh becomes owed on the first clock edge after reset is released, and another every L = `cfg_interval` cycles after that.
- R3: With `temp_hot`=1, the reload length is `cfg_interval` shifted right by one bit (twice the refresh rate).
- R4: With `pb_mode`=1, the reload length is further shifted right by log2(NUM_BANKS), on top of the shift from R3. A computed length of 0 is raised to 1.
- R5: The values of `temp_hot` and `pb_mode` are sampled only on the edge where the timer reloads, so a change never shortens or stretches an interval already counting.
- R6: In all-bank mode, `ref_req` is high only while a refresh is owed and every bank is idle. An accepted request (`ref_req` and `ref_ack` both high on an edge) sets all `bank_busy` bits for exactly `cfg_trfc` cycles, starting the cycle after the accept.
- R7: In per-bank mode, `ref_req` is high only while a refresh is owed and bank `ref_bank` is idle. An accept sets only bit `ref_bank` of `bank_busy` for exactly `cfg_trfc` cycles. The other bits are untouched.
- R8: `ref_bank` advances 0, 1, …, NUM_BANKS-1 and wraps to 0, by one step per per-bank accept only. All-bank accepts leave it unchanged.
- R9: Owed refreshes that are not accepted accumulate up to a limit of 8; further expiries beyond 8 are dropped. `ref_urgent` is 1 exactly while 8 refreshes are owed.
- R10: Each accept retires one owed refresh. When no refresh is owed, `ref_req` is 0. An accept made while 8 are owed lowers `ref_urgent` unless the timer expires on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | CNT_W | All-bank refresh interval in cycles at normal temperature |
| cfg_trfc | input | CNT_W | Cycles a bank stays busy after a refresh |
| temp_hot | input | 1 | 1 while the device temperature reading is above the high threshold |
| pb_mode | input | 1 | 1 = per-bank refresh, 0 = all-bank refresh |
| ref_ack | input | 1 | Arbiter accepts the refresh request on this edge |
| ref_req | output | 1 | A refresh command is ready to issue |
| ref_bank | output | BANK_W | Bank targeted by a per-bank refresh |
| ref_urgent | output | 1 | Postponement limit reached; refresh must go next |
| bank_busy | output | NUM_BANKS | Per-bank refresh-in-progress flags |

## Verification
The bench builds the block with four banks and a 16-bit counter width, so the per-bank shift is two bits and every bank-rotation wrap is reached within a few intervals. It sweeps every interval value from 4 to 40 across all four temperature/mode combinations. This covers odd values where the shifts truncate, and it covers the clamp that turns a zero-length per-bank interval into one cycle. Directed runs use refresh cycle times longer than the interval to exercise the busy-gating hold-off in both modes. They toggle temperature and mode in the middle of an interval, and they hold off acceptance long enough to drive the owed count past its limit of eight.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int unsigned DEBT_LIMIT = 8;
  localparam int unsigned DEBT_W     = $clog2(DEBT_LIMIT + 1);
  typedef logic [DEBT_W-1:0] debt_t;
endpackage

// File: rtl/refresh_interval_timer.sv
// Down-counter that fires one tick per refresh interval; the reload length
// is chosen from temperature and mode only when the counter wraps.
module refresh_interval_timer #(
  parameter int CNT_W   = 16,
  parameter int BANK_SH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic             hot,
  input  logic             per_bank,
  output logic             tick
);
  localparam int SH_W = $clog2(BANK_SH + 2) + 1;

  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W-1:0] tmr_d;
  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] reload;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    shamt  = SH_W'(hot) + (per_bank ? SH_W'(BANK_SH) : '0);
    scaled = cfg_interval >> shamt;
    reload = (scaled == '0) ? CNT_W'(1) : scaled;
    tick   = (tmr_q == '0);
    tmr_d  = tick ? (reload - CNT_W'(1)) : (tmr_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/refresh_debt_ctr.sv
// Counts refreshes that are owed but not yet accepted, saturating at the limit.
module refresh_debt_ctr
  import refresh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  retire,
  output debt_t debt,
  output logic  owed,
  output logic  urgent
);
  logic [DEBT_W:0] sum;
  debt_t           debt_q;
  debt_t           debt_d;
  logic            debt_en;

  always_comb begin
    sum     = {1'b0, debt_q} + (DEBT_W+1)'(tick) - (DEBT_W+1)'(retire);
    debt_d  = (sum > (DEBT_W+1)'(DEBT_LIMIT)) ? DEBT_W'(DEBT_LIMIT) : sum[DEBT_W-1:0];
    debt_en = tick | retire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt_q <= '0;
    end else if (debt_en) begin
      debt_q <= debt_d;
    end
  end

  assign debt   = debt_q;
  assign owed   = (debt_q != '0);
  assign urgent = (debt_q == DEBT_W'(DEBT_LIMIT));
endmodule

// File: rtl/refresh_bank_busy.sv
// Holds one bank busy for the programmed refresh cycle time after a start.
module refresh_bank_busy #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_trfc,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != '0);
    cnt_d  = start ? cfg_trfc : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/refresh_sched.sv
// Refresh scheduler top. NUM_BANKS must be a power of two, at least 2.
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cfg_interval,
  input  logic [CNT_W-1:0]     cfg_trfc,
  input  logic                 temp_hot,
  input  logic                 pb_mode,
  input  logic                 ref_ack,
  output logic                 ref_req,
  output logic [$clog2(NUM_BANKS)-1:0] ref_bank,
  output logic                 ref_urgent,
  output logic [NUM_BANKS-1:0] bank_busy
);
  localparam int BANK_SH = $clog2(NUM_BANKS);
  localparam int BANK_W  = BANK_SH;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic              tick;
  logic              owed;
  logic              grant;
  debt_t             debt_q;
  logic [BANK_W-1:0] ptr_q;
  logic [BANK_W-1:0] ptr_d;
  logic              ptr_en;
  logic [NUM_BANKS-1:0] start;

  refresh_interval_timer #(
    .CNT_W   (CNT_W),
    .BANK_SH (BANK_SH)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_interval (cfg_interval),
    .hot          (temp_hot),
    .per_bank     (pb_mode),
    .tick         (tick)
  );

  refresh_debt_ctr u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .retire (grant),
    .debt   (debt_q),
    .owed   (owed),
    .urgent (ref_urgent)
  );

  always_comb begin
    ref_req = owed & (pb_mode ? ~bank_busy[ptr_q] : (bank_busy == '0));
    grant   = ref_req & ref_ack;
    ptr_en  = grant & pb_mode;
    ptr_d   = (ptr_q == LAST_BANK) ? '0 : (ptr_q + BANK_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign start[b] = grant & (~pb_mode | (ptr_q == BANK_W'(b)));
    refresh_bank_busy #(
      .CNT_W (CNT_W)
    ) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start[b]),
      .cfg_trfc (cfg_trfc),
      .busy     (bank_busy[b])
    );
  end

  assign ref_bank = ptr_q;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk
  import refresh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_req,
  input logic                 ref_ack,
  input logic                 ref_urgent,
  input logic                 pb_mode,
  input logic [$clog2(NUM_BANKS)-1:0] ref_bank,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic [CNT_W-1:0]     cfg_trfc,
  input debt_t                debt
);
  localparam int BW = $clog2(NUM_BANKS);

  a_r9_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DEBT_W'(DEBT_LIMIT));

  a_r10_req_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (debt != '0));

  a_r6_all_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !pb_mode) |-> (bank_busy == '0));

  a_r7_target_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && pb_mode) |-> !bank_busy[ref_bank]);

  a_r7_bank_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack && pb_mode && cfg_trfc != '0) |=> bank_busy[$past(ref_bank)]);

  a_r8_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack && pb_mode) |=>
      (ref_bank == (($past(ref_bank) == BW'(NUM_BANKS - 1)) ? '0 : $past(ref_bank) + BW'(1))));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && ref_ack && pb_mode) |=> $stable(ref_bank));

  a_r9_urgent_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (ref_req || bank_busy != '0));
endmodule

bind refresh_sched refresh_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_req    (ref_req),
  .ref_ack    (ref_ack),
  .ref_urgent (ref_urgent),
  .pb_mode    (pb_mode),
  .ref_bank   (ref_bank),
  .bank_busy  (bank_busy),
  .cfg_trfc   (cfg_trfc),
  .debt       (debt_q)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int W  = 16;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  cfg_interval;
  logic [W-1:0]  cfg_trfc;
  logic          temp_hot;
  logic          pb_mode;
  logic          ref_ack;
  logic          ref_req;
  logic [1:0]    ref_bank;
  logic          ref_urgent;
  logic [NB-1:0] bank_busy;

  int checks = 0;
  int fails  = 0;
  int n;

  refresh_sched #(.NUM_BANKS(NB), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_trfc(cfg_trfc),
    .temp_hot(temp_hot), .pb_mode(pb_mode), .ref_ack(ref_ack),
    .ref_req(ref_req), .ref_bank(ref_bank), .ref_urgent(ref_urgent),
    .bank_busy(bank_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at step %0d: actual=%0d expected=%0d", req, n, act, exp);
    end
  endtask

  function automatic int eff_len(input int iv, input bit hot, input bit pb);
    int l;
    l = iv >> (int'(hot) + (pb ? 2 : 0));
    return (l == 0) ? 1 : l;
  endfunction

  task automatic restart(input int iv, input int trfc, input bit hot, input bit pb, input bit ack);
    @(negedge clk);
    cfg_interval = W'(iv);
    cfg_trfc     = W'(trfc);
    temp_hot     = hot;
    pb_mode      = pb;
    ref_ack      = ack;
    rst_n        = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ref_req == 1'b0, "R1 req", int'(ref_req), 0);
    chk(ref_urgent == 1'b0, "R1 urgent", int'(ref_urgent), 0);
    chk(bank_busy == '0, "R1 busy", int'(bank_busy), 0);
    chk(ref_bank == '0, "R1 bank", int'(ref_bank), 0);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int len, bank, prev_bank, last_r, last_b, cnt;
    bit prev_req, exp_req;
    logic [NB-1:0] exp_busy;
    string tag;

    rst_n = 1'b0; cfg_interval = '0; cfg_trfc = '0;
    temp_hot = 1'b0; pb_mode = 1'b0; ref_ack = 1'b0; n = 0;

    // Sweep: spacing (R2, R3, R4), rotation (R8), one-cycle busy (R6, R7)
    for (int iv = 4; iv <= 40; iv++) begin
      for (int m = 0; m < 4; m++) begin
        len = eff_len(iv, m[0], m[1]);
        tag = m[1] ? "R4" : (m[0] ? "R3" : "R2");
        restart(iv, 1, m[0], m[1], 1'b1);
        prev_req = 1'b0; bank = 0; prev_bank = 0;
        for (int k = 1; k <= 4*len + 2; k++) begin
          step();
          exp_req = ((n - 1) % len) == 0;
          chk(ref_req == exp_req, tag, int'(ref_req), int'(exp_req));
          if (m[1] && exp_req)
            chk(ref_bank == 2'(bank % NB), "R8 order", int'(ref_bank), bank % NB);
          exp_busy = prev_req ? (m[1] ? NB'(1 << prev_bank) : '1) : '0;
          chk(bank_busy == exp_busy, m[1] ? "R7 busy" : "R6 busy", int'(bank_busy), int'(exp_busy));
          prev_req = exp_req;
          if (exp_req) begin
            prev_bank = bank % NB;
            bank++;
          end
        end
      end
    end

    // R5: temperature change mid-interval waits for the reload
    restart(40, 1, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 101; k++) begin
      step();
      if (n == 11) temp_hot = 1'b1;
      exp_req = (n == 1) || (n == 41) || (n > 41 && ((n - 41) % 20) == 0);
      chk(ref_req == exp_req, "R5 hot", int'(ref_req), int'(exp_req));
    end

    // R5: mode change mid-interval waits for the reload
    restart(64, 1, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 100; k++) begin
      step();
      if (n == 5) pb_mode = 1'b1;
      exp_req = (n == 1) || (n == 65) || (n > 65 && ((n - 65) % 16) == 0);
      chk(ref_req == exp_req, "R5 mode", int'(ref_req), int'(exp_req));
      if (n == 65) chk(ref_bank == 2'd0, "R8 all-bank no advance", int'(ref_bank), 0);
    end

    // R7: per-bank busy lasts cfg_trfc cycles on the addressed bank only
    restart(64, 5, 1'b0, 1'b1, 1'b1);
    last_r = -100; last_b = 0; bank = 0;
    for (int k = 1; k <= 70; k++) begin
      step();
      exp_busy = (n >= last_r + 1 && n <= last_r + 5) ? NB'(1 << last_b) : '0;
      chk(bank_busy == exp_busy, "R7 duration", int'(bank_busy), int'(exp_busy));
      if (((n - 1) % 16) == 0) begin
        last_r = n; last_b = bank % NB; bank++;
      end
    end

    // R6: all-bank busy lasts cfg_trfc cycles on every bank
    restart(32, 5, 1'b0, 1'b0, 1'b1);
    last_r = -100;
    for (int k = 1; k <= 70; k++) begin
      step();
      exp_busy = (n >= last_r + 1 && n <= last_r + 5) ? '1 : '0;
      chk(bank_busy == exp_busy, "R6 duration", int'(bank_busy), int'(exp_busy));
      if (((n - 1) % 32) == 0) last_r = n;
    end

    // R6: request held off while any bank is busy
    restart(8, 20, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k <= 200; k++) begin
      step();
      exp_req = ((n - 1) % 21) == 0;
      chk(ref_req == exp_req, "R6 hold-off", int'(ref_req), int'(exp_req));
    end

    // R7: per-bank request held off while its own bank is busy
    restart(16, 20, 1'b0, 1'b1, 1'b1);
    for (int k = 1; k <= 22; k++) begin
      step();
      if (n == 10) chk(bank_busy == 4'b0111, "R7 others", int'(bank_busy), 7);
      if (n >= 14 && n <= 21) chk(ref_req == 1'b0, "R7 hold-off", int'(ref_req), 0);
      if (n == 22) begin
        chk(ref_req == 1'b1, "R7 release", int'(ref_req), 1);
        chk(ref_bank == 2'd0, "R8 wrap", int'(ref_bank), 0);
      end
    end

    // R9 / R10: postponement count and saturation
    restart(200, 2, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= 1810; k++) begin
      step();
      cnt = (n - 1) / 200 + 1;
      chk(ref_urgent == (cnt >= 8), "R9 urgent", int'(ref_urgent), int'(cnt >= 8));
      chk(ref_req == 1'b1, "R9 req held", int'(ref_req), 1);
    end
    ref_ack = 1'b1;
    cnt = 1;
    for (int k = 1; k <= 180; k++) begin
      step();
      if (n == 1811) chk(ref_urgent == 1'b0, "R10 urgent drop", int'(ref_urgent), 0);
      if (ref_req) cnt++;
    end
    chk(cnt == 8, "R9 saturation", cnt, 8);
    for (int k = 1; k <= 11; k++) begin
      step();
      if (n == 1995) chk(ref_req == 1'b0, "R10 drained", int'(ref_req), 0);
      if (n == 2001) chk(ref_req == 1'b1, "R10 next", int'(ref_req), 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule